// File: doc/BRIEF.md
# ISA-Style DMA Channel Programming Registers

This block is the processor side of a four-channel DMA controller of the classic PC type. Software talks to it through 8-bit I/O reads and writes at sixteen low port offsets. Each channel keeps a 16-bit start address and a 16-bit transfer count. Both exist as a base copy and as a working copy. The channel also keeps a mode byte, a mask bit, an 8-bit page byte that supplies address bits 23:16, and a high-page byte that supplies bits 31:24.

The data path is one byte wide, so the 16-bit values are loaded and read back in two steps. A single byte-pointer flip-flop, shared by all channels, decides which half each access reaches. Software can force that flip-flop back to the low half by writing to a dedicated port.

The transfer engine sits outside this block. It reads the programmed values from the output buses. It signals each completed transfer on a per-channel step strobe, which moves the working address and count forward. It also reports pending requests, and these appear in the status byte.

Top module: `dma_cfg_regs`

## Requirements
- R1: After reset, all mask bits are set. The command byte, every mode byte, every address, count and page value, and the read data are zero, and the byte pointer selects the low half.
- R2: Writing an address port (offset 2*ch) or a count port (offset 2*ch+1) loads the byte chosen by the pointer into both the base and the working copy. The first write after a pointer clear loads bits 7:0 and the next one loads bits 15:8.
- R3: Any write to offset 0x0C returns the byte pointer to the low half, whatever data is written.
- R4: The byte pointer is shared. Every read or write to any of the offsets 0x00–0x07 toggles it, whatever the channel or register.
- R5: A read of an address or count port returns the working value in the byte chosen by the pointer, low byte first and then high byte. The data appears on bus_rdata one clock after the read strobe.
- R6: A write to offset 0x0A picks a channel with data bits 1:0. Data bit 2 set masks that channel, and bit 2 clear unmasks it. Other channels keep their mask bits.
- R7: A write to offset 0x0B stores the whole data byte as the mode of the channel named in bits 1:0. In that byte, bits 3:2 give the transfer type (01 device to memory, 10 memory to device), bit 4 enables auto-initialise, and bits 7:6 give the mode (01 single, 11 cascade).
- R8: A write to offset 0x0E clears all four mask bits. A write to offset 0x0F loads the mask bits from data bits 3:0.
- R9: A write to offset 0x0D (master clear) sets all mask bits, returns the pointer to the low half, and clears the command byte and the latched terminal-count flags. A read of 0x0D returns 0x00.
- R10: A page write with page_hi=0 loads the page byte of channel page_chan, and with page_hi=1 loads the high-page byte. The channel's 32-bit address output is {high page, page, working address}.
- R11: A step strobe decrements the working count and increments the working address. A step when the count is 0 latches that channel's terminal-count flag. If the channel's mode bit 4 is set, that step reloads both working values from their base copies; if not, the count wraps to 0xFFFF.
- R12: A write to offset 0x08 loads the command byte. A read of 0x08 returns status as {eng_req[3:0], terminal-count flags[3:0]} and clears the terminal-count flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register port offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data, also page data |
| bus_rdata | output | 8 | Registered read data |
| page_wr | input | 1 | Page register write strobe |
| page_hi | input | 1 | 0: page byte, 1: high-page byte |
| page_chan | input | 2 | Channel of the page write |
| eng_step | input | 4 | Per-channel transfer-done strobe |
| eng_req | input | 4 | Per-channel pending request, shown in status |
| cmd_out | output | 8 | Command byte |
| mask_out | output | 4 | Per-channel mask bits |
| mode_out | output | 32 | Mode bytes, channel n at bits 8n+7:8n |
| addr_out | output | 128 | 32-bit working addresses, channel n at bits 32n+31:32n |
| count_out | output | 64 | Working counts, channel n at bits 16n+15:16n |

## Verification
The hardest case to reach from the ports is the shared pointer left in the high-half state by one channel and then used by another. The stimulus writes one byte to a channel-1 address port and then one byte to a channel-2 count port, and expects it in the high byte. It also repeats a single write around a pointer clear and around a master clear, so that the result shows which half the pointer chose. Terminal count is reached by loading a count of 1 or 0 and stepping a channel. The auto-initialise and the wrap outcomes are told apart through count_out and status reads.

// File: rtl/dma_cfg_pkg.sv
// Package: shared port offsets, mode field positions and widths for the
// DMA channel programming registers.
package dma_cfg_pkg;
    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned WORD_W       = 16;
    localparam int unsigned PAGE_W       = 8;
    localparam int unsigned FULL_ADDR_W  = WORD_W + 2 * PAGE_W;

    // Port offsets whose values software depends on
    localparam logic [3:0] OFS_CMD_STAT  = 4'h8;
    localparam logic [3:0] OFS_ONE_MASK  = 4'hA;
    localparam logic [3:0] OFS_MODE      = 4'hB;
    localparam logic [3:0] OFS_PTR_CLR   = 4'hC;
    localparam logic [3:0] OFS_MCLR_TMP  = 4'hD;
    localparam logic [3:0] OFS_MASK_CLR  = 4'hE;
    localparam logic [3:0] OFS_MASK_ALL  = 4'hF;

    // Mode byte fields
    localparam int unsigned MODE_AUTOINIT_BIT = 4;
    localparam int unsigned MASK_SET_BIT      = 2;

    // Which half of a 16-bit register the pointer selects
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/dma_byte_ptr.sv
// Module: dma_byte_ptr
// Holds the single low/high byte pointer shared by all channels.
// Assumes: clear has priority over toggle; both are one-cycle strobes.
module dma_byte_ptr
    import dma_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  toggle,
    output half_e half
);
    // Pointer state: reset/clear to low half, flip on each 16-bit port access
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            half <= HALF_LO;
        end else if (toggle) begin
            half <= (half == HALF_LO) ? HALF_HI : HALF_LO;
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
// Module: dma_chan_regs
// One channel's base and working address/count registers.
// Assumes: byte writes and engine steps never occur in the same cycle for
// the same channel; a write takes priority if they do.
module dma_chan_regs
    import dma_cfg_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_cnt,     // 1: count register, 0: address register
    input  half_e         wr_half,
    input  logic [7:0]    wdata,
    input  logic          step,
    input  logic          autoinit,
    output logic [W-1:0]  cur_addr,
    output logic [W-1:0]  cur_cnt,
    output logic          tc_hit
);
    localparam int unsigned HI_LSB = 8;

    logic [W-1:0] base_addr;
    logic [W-1:0] base_cnt;

    // Terminal count: a step taken while the working count is zero
    assign tc_hit = step && (cur_cnt == '0);

    // Base copies: loaded only by software byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
        end else if (wr_en) begin
            if (wr_cnt) begin
                if (wr_half == HALF_LO) base_cnt[7:0]        <= wdata;
                else                    base_cnt[HI_LSB+:8]  <= wdata;
            end else begin
                if (wr_half == HALF_LO) base_addr[7:0]       <= wdata;
                else                    base_addr[HI_LSB+:8] <= wdata;
            end
        end
    end

    // Working copies: software writes, engine steps, auto-initialise reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
        end else if (wr_en) begin
            if (wr_cnt) begin
                if (wr_half == HALF_LO) cur_cnt[7:0]        <= wdata;
                else                    cur_cnt[HI_LSB+:8]  <= wdata;
            end else begin
                if (wr_half == HALF_LO) cur_addr[7:0]       <= wdata;
                else                    cur_addr[HI_LSB+:8] <= wdata;
            end
        end else if (step) begin
            if (tc_hit && autoinit) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else begin
                cur_addr <= cur_addr + 1'b1;
                cur_cnt  <= cur_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_page_regs.sv
// Module: dma_page_regs
// Page (address bits 23:16) and high-page (bits 31:24) bytes per channel.
// Assumes: one page write per cycle, selected by channel and half.
module dma_page_regs
    import dma_cfg_pkg::*;
#(
    parameter int unsigned NCH  = 4,
    parameter int unsigned CH_W = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic                    hi,
    input  logic [CH_W-1:0]         chan,
    input  logic [PAGE_W-1:0]       wdata,
    output logic [NCH*PAGE_W-1:0]   page,
    output logic [NCH*PAGE_W-1:0]   hipage
);
    for (genvar g = 0; g < NCH; g++) begin : g_pg
        // Per-channel page bytes, written through the shared page strobe
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page[g*PAGE_W +: PAGE_W]   <= '0;
                hipage[g*PAGE_W +: PAGE_W] <= '0;
            end else if (wr && (chan == CH_W'(g))) begin
                if (hi) hipage[g*PAGE_W +: PAGE_W] <= wdata;
                else    page[g*PAGE_W +: PAGE_W]   <= wdata;
            end
        end
    end
endmodule

// File: rtl/dma_cfg_regs.sv
// Module: dma_cfg_regs
// Processor-facing register file of a four-channel DMA controller: port
// decode, shared byte pointer, masks, modes, command, status and pages.
// Assumes: bus_wr and bus_rd are one-cycle strobes, never high together;
// NCH is at most 4 so that mask-all and status fit one byte.
module dma_cfg_regs
    import dma_cfg_pkg::*;
#(
    parameter int unsigned NCH  = 4,
    parameter int unsigned CH_W = $clog2(NCH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [3:0]                  bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [7:0]                  bus_wdata,
    output logic [7:0]                  bus_rdata,
    input  logic                        page_wr,
    input  logic                        page_hi,
    input  logic [CH_W-1:0]             page_chan,
    input  logic [NCH-1:0]              eng_step,
    input  logic [NCH-1:0]              eng_req,
    output logic [7:0]                  cmd_out,
    output logic [NCH-1:0]              mask_out,
    output logic [NCH*8-1:0]            mode_out,
    output logic [NCH*FULL_ADDR_W-1:0]  addr_out,
    output logic [NCH*WORD_W-1:0]       count_out
);
    localparam int unsigned NPORT = 2 * NCH;

    // Decode of the current access
    logic            chan_port;
    logic [CH_W-1:0] port_ch;
    logic            port_is_cnt;
    logic [CH_W-1:0] data_ch;
    logic            wr_ptr_clr, wr_mclr, wr_cmd, wr_one_mask;
    logic            wr_mode, wr_mask_clr, wr_mask_all, rd_status;
    half_e           ptr_half;

    assign chan_port   = ({1'b0, bus_addr} < 5'(NPORT));
    assign port_ch     = bus_addr[CH_W:1];
    assign port_is_cnt = bus_addr[0];
    assign data_ch     = bus_wdata[CH_W-1:0];
    assign wr_ptr_clr  = bus_wr && (bus_addr == OFS_PTR_CLR);
    assign wr_mclr     = bus_wr && (bus_addr == OFS_MCLR_TMP);
    assign wr_cmd      = bus_wr && (bus_addr == OFS_CMD_STAT);
    assign wr_one_mask = bus_wr && (bus_addr == OFS_ONE_MASK);
    assign wr_mode     = bus_wr && (bus_addr == OFS_MODE);
    assign wr_mask_clr = bus_wr && (bus_addr == OFS_MASK_CLR);
    assign wr_mask_all = bus_wr && (bus_addr == OFS_MASK_ALL);
    assign rd_status   = bus_rd && (bus_addr == OFS_CMD_STAT);

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (wr_ptr_clr || wr_mclr),
        .toggle ((bus_wr || bus_rd) && chan_port),
        .half   (ptr_half)
    );

    logic [WORD_W-1:0] cur_addr [NCH];
    logic [WORD_W-1:0] cur_cnt  [NCH];
    logic [NCH-1:0]    tc_vec;
    logic [7:0]        mode_q   [NCH];
    logic [NCH*PAGE_W-1:0] page_v, hipage_v;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_chan_regs #(.W(WORD_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr && chan_port && (port_ch == CH_W'(g))),
            .wr_cnt   (port_is_cnt),
            .wr_half  (ptr_half),
            .wdata    (bus_wdata),
            .step     (eng_step[g]),
            .autoinit (mode_q[g][MODE_AUTOINIT_BIT]),
            .cur_addr (cur_addr[g]),
            .cur_cnt  (cur_cnt[g]),
            .tc_hit   (tc_vec[g])
        );

        // Mode byte of this channel, chosen by the low data bits
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[g] <= '0;
            end else if (wr_mode && (data_ch == CH_W'(g))) begin
                mode_q[g] <= bus_wdata;
            end
        end

        assign mode_out[g*8 +: 8]      = mode_q[g];
        assign count_out[g*WORD_W +: WORD_W] = cur_cnt[g];
        assign addr_out[g*FULL_ADDR_W +: FULL_ADDR_W] =
            {hipage_v[g*PAGE_W +: PAGE_W], page_v[g*PAGE_W +: PAGE_W], cur_addr[g]};
    end

    dma_page_regs #(.NCH(NCH), .CH_W(CH_W)) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (page_wr),
        .hi     (page_hi),
        .chan   (page_chan),
        .wdata  (bus_wdata),
        .page   (page_v),
        .hipage (hipage_v)
    );

    // Mask bits: reset and master clear set all; single, clear-all, write-all
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr) begin
            mask_out <= '1;
        end else if (wr_mask_clr) begin
            mask_out <= '0;
        end else if (wr_mask_all) begin
            mask_out <= bus_wdata[NCH-1:0];
        end else if (wr_one_mask) begin
            mask_out[data_ch] <= bus_wdata[MASK_SET_BIT];
        end
    end

    // Command byte: loaded at the command port, cleared by master clear
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr) begin
            cmd_out <= '0;
        end else if (wr_cmd) begin
            cmd_out <= bus_wdata;
        end
    end

    // Terminal-count flags: set by engine, cleared by status read or master clear
    logic [NCH-1:0] tc_flags;
    always_ff @(posedge clk) begin
        if (!rst_n || wr_mclr) begin
            tc_flags <= '0;
        end else begin
            tc_flags <= (rd_status ? '0 : tc_flags) | tc_vec;
        end
    end

    logic [7:0] status_byte;
    always_comb begin
        status_byte = '0;
        status_byte[NCH-1:0] = tc_flags;
        status_byte[4 +: NCH] = eng_req;
    end

    // Read data: selected byte registered one cycle after the read strobe
    logic [WORD_W-1:0] rd_word;
    assign rd_word = port_is_cnt ? cur_cnt[port_ch] : cur_addr[port_ch];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (chan_port) begin
                bus_rdata <= (ptr_half == HALF_LO) ? rd_word[7:0] : rd_word[15:8];
            end else if (bus_addr == OFS_CMD_STAT) begin
                bus_rdata <= status_byte;
            end else begin
                bus_rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/dma_cfg_regs_chk.sv
// Module: dma_cfg_regs_chk
// Temporal checks on the register block, attached through bind.
// Assumes: bus_wr and bus_rd are never high together.
module dma_cfg_regs_chk
    import dma_cfg_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [3:0]     bus_addr,
    input logic           bus_wr,
    input logic           bus_rd,
    input logic [7:0]     bus_wdata,
    input logic [NCH-1:0] mask_out,
    input logic [7:0]     cmd_out,
    input half_e          ptr_half
);
    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_PTR_CLR) |=> (ptr_half == HALF_LO));

    assert_ptr_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr ^ bus_rd) && bus_addr < 4'(2*NCH)) |=> (ptr_half != $past(ptr_half)));

    assert_one_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_ONE_MASK)
        |=> (mask_out[$past(bus_wdata[1:0])] == $past(bus_wdata[MASK_SET_BIT])));

    assert_mask_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MASK_CLR) |=> (mask_out == '0));

    assert_master_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MCLR_TMP)
        |=> (mask_out == '1 && cmd_out == 8'h00 && ptr_half == HALF_LO));

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr) |=> $stable(mask_out));
endmodule

bind dma_cfg_regs dma_cfg_regs_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .mask_out  (mask_out),
    .cmd_out   (cmd_out),
    .ptr_half  (ptr_half)
);

// File: tb/dma_cfg_regs_bench.sv
`timescale 1ns/1ps
module dma_cfg_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        page_wr = 1'b0, page_hi = 1'b0;
    logic [1:0]  page_chan = '0;
    logic [3:0]  eng_step = '0, eng_req = '0;
    logic [7:0]  cmd_out;
    logic [3:0]  mask_out;
    logic [31:0] mode_out;
    logic [127:0] addr_out;
    logic [63:0] count_out;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    dma_cfg_regs u_dma_cfg_regs (
        .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
        .page_wr, .page_hi, .page_chan, .eng_step, .eng_req,
        .cmd_out, .mask_out, .mode_out, .addr_out, .count_out
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    // Driver: queue the expected byte, then issue the read
    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic pg(input logic [1:0] ch, input logic hi, input logic [7:0] d);
        @(negedge clk); page_chan = ch; page_hi = hi; bus_wdata = d; page_wr = 1'b1;
        @(negedge clk); page_wr = 1'b0;
    endtask

    task automatic step(input logic [3:0] m);
        @(negedge clk); eng_step = m;
        @(negedge clk); eng_step = '0;
    endtask

    // Monitor: read data is valid one cycle after the strobe
    always @(posedge clk) rd_seen <= bus_rd && rst_n;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", 64'(mask_out), 64'hF);
        chk("R1 cmd/mode", {24'(cmd_out), mode_out}, 64'h0);
        chk("R1 count", count_out, 64'h0);
        chk("R1 rdata", 64'(bus_rdata), 64'h0);
        // R12 command write
        wr(4'h8, 8'h5A);
        chk("R12 cmd", 64'(cmd_out), 64'h5A);
        // R2 two-byte loads
        wr(4'hC, 8'h00);
        wr(4'h1, 8'h34); wr(4'h1, 8'h12);
        chk("R2 ch0 count", 64'(count_out[15:0]), 64'h1234);
        wr(4'h0, 8'hCD); wr(4'h0, 8'hAB);
        chk("R2 ch0 addr", 64'(addr_out[15:0]), 64'hABCD);
        // R5 readback low then high
        rd(4'h1, 8'h34, "R5 count lo");
        rd(4'h1, 8'h12, "R5 count hi");
        // R4 shared pointer across channels
        wr(4'h2, 8'h11);
        wr(4'h5, 8'h77);
        chk("R4 ch2 count hi", 64'(count_out[47:32]), 64'h7700);
        // R3 pointer clear
        wr(4'h6, 8'h22); wr(4'hC, 8'hFF); wr(4'h6, 8'h33);
        chk("R3 ch3 addr", 64'(addr_out[111:96]), 64'h0033);
        wr(4'hC, 8'h00);
        // R6 single mask
        wr(4'hA, 8'h01);
        chk("R6 unmask ch1", 64'(mask_out), 64'hD);
        wr(4'hA, 8'h05);
        chk("R6 mask ch1", 64'(mask_out), 64'hF);
        // R8 clear-all and write-all
        wr(4'hE, 8'h00);
        chk("R8 clear all", 64'(mask_out), 64'h0);
        wr(4'hF, 8'hFA);
        chk("R8 write all", 64'(mask_out), 64'hA);
        // R7 mode bytes
        wr(4'hB, 8'h46);
        wr(4'hB, 8'h59);
        chk("R7 modes", 64'(mode_out), 64'h0046_5900);
        // R10 page and high page
        pg(2'd1, 1'b0, 8'h3C); pg(2'd1, 1'b1, 8'h7E);
        chk("R10 ch1 addr", 64'(addr_out[63:32]), 64'h7E3C0011);
        // R11 step on ch0
        step(4'b0001);
        chk("R11 ch0 count", 64'(count_out[15:0]), 64'h1233);
        chk("R11 ch0 addr", 64'(addr_out[15:0]), 64'hABCE);
        rd(4'h1, 8'h33, "R11 read lo");
        rd(4'h1, 8'h12, "R11 read hi");
        // R11 terminal count with auto-initialise on ch1
        wr(4'h3, 8'h01); wr(4'h3, 8'h00);
        step(4'b0010);
        chk("R11 ch1 count 0", 64'(count_out[31:16]), 64'h0);
        step(4'b0010);
        chk("R11 ch1 reload count", 64'(count_out[31:16]), 64'h0001);
        chk("R11 ch1 reload addr", 64'(addr_out[47:32]), 64'h0011);
        eng_req = 4'b0100;
        rd(4'h8, 8'h42, "R12 status tc+req");
        rd(4'h8, 8'h40, "R12 status cleared");
        eng_req = 4'b0000;
        // R11 terminal count without auto-initialise on ch3
        wr(4'h7, 8'h00); wr(4'h7, 8'h00);
        step(4'b1000);
        chk("R11 ch3 wrap", 64'(count_out[63:48]), 64'hFFFF);
        chk("R11 ch3 addr", 64'(addr_out[111:96]), 64'h0034);
        rd(4'h8, 8'h08, "R11 status ch3");
        // R9 master clear
        wr(4'h7, 8'h00); wr(4'h7, 8'h00);
        step(4'b1000);
        wr(4'hF, 8'h00);
        wr(4'h0, 8'h55);
        wr(4'hD, 8'h00);
        chk("R9 mask", 64'(mask_out), 64'hF);
        chk("R9 cmd", 64'(cmd_out), 64'h0);
        wr(4'h1, 8'h99);
        chk("R9 pointer low", 64'(count_out[15:0]), 64'h1299);
        rd(4'h8, 8'h00, "R9 status cleared");
        rd(4'hD, 8'h00, "R9 temp read");
        @(negedge clk);
        chk("scoreboard drained", 64'(exp_q.size()), 64'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule